// File: doc/BRIEF.md
# YCbCr 4:4:4 to 4:2:2 Chroma Subsampler

This block takes a pixel stream with full-resolution color (one luma and two chroma samples per pixel, 8 bits each by default) and halves the chroma rate. Each output word keeps the luma of its own pixel. Its chroma byte alternates between the two color-difference components from one pixel to the next. Neighbouring pixels are grouped in pairs. The chroma value sent for each pixel is the rounded average of that component across the pair. A build-time parameter chooses which component leads each pair.

A runtime bypass input forwards the whole input pixel unchanged. This lets a test pattern or an RGB stream reach the transmitter untouched. Data-enable and the two sync lines travel alongside the data through the same two-register pipeline, so timing stays aligned in either mode.

Top module: `chroma_sub422`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: `out_de`, `out_hs` and `out_vs` equal `in_de`, `in_hs` and `in_vs` delayed by exactly two clock edges.
- R3: In subsampling mode `out_pix[23:16]` is zero and `out_pix[7:0]` is the luma of the same pixel, taken from input bits [15:8] two edges earlier.
- R4: Input bits [23:16] carry Cr and bits [7:0] carry Cb. Pixels at even positions of an active run (counting from 0) carry the leading component in `out_pix[15:8]`. The leading component is Cb when `CR_FIRST`=0 (the default) and Cr when `CR_FIRST`=1. Odd positions carry the other component.
- R5: The chroma value sent is (a+b+1)>>1. Here a and b are the component in question for the two pixels of the pair (positions 2k and 2k+1).
- R6: Position counting restarts at 0 on each rising edge of `in_de`, so every active run begins with the leading component.
- R7: If a run has an odd length, its last pixel has no partner. Its chroma is then its own leading component, unaveraged.
- R8: When `bypass` is 1, `out_pix` equals the full 24-bit input pixel from two edges earlier.
- R9: `bypass` is sampled at the edge that loads the output. A change therefore affects the pixel that leaves at that edge, even in the middle of a line, and the pairing state is not disturbed.
- R10: In subsampling mode, `out_pix` is zero whenever `out_de` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | 1 forwards the input pixel unmodified |
| in_de | input | 1 | Input data enable |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_pix | input | 24 | Input pixel {Cr, Y, Cb} |
| out_de | output | 1 | Delayed data enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_pix | output | 24 | {0, chroma, Y} when subsampling; input pixel when bypassed |

## Verification
Two behaviours can fall in the same cycle. One is the end of an odd-length run, where the last pixel must fall back to its own chroma. The other is the restart of the pair count on the next rising data enable. Lines separated by a single blanking cycle create this collision. A `bypass` toggle in the middle of an odd line also lands on a pixel whose partner is in flight. A behavioural model tracks each pixel's run position and partner from the recorded input history. It is compared with both parameter variants on every clock, so any slip in pairing or rounding shows up at the exact pixel.

// File: rtl/chroma_sub422.sv
module chroma_sub422 #(
  parameter bit CR_FIRST = 1'b0,
  parameter int CW       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic              in_de,
  input  logic              in_hs,
  input  logic              in_vs,
  input  logic [3*CW-1:0]   in_pix,
  output logic              out_de,
  output logic              out_hs,
  output logic              out_vs,
  output logic [3*CW-1:0]   out_pix
);
  localparam int PW = 3*CW;

  logic [PW-1:0] s1_pix, s2_pix, mate;
  logic          s1_de, s1_hs, s1_vs, ph;
  logic [1:0]    warm;
  logic [CW-1:0] ca, cb, chroma;
  logic [CW:0]   sum;

  function automatic logic [CW-1:0] lead_c(input logic [PW-1:0] p);
    return CR_FIRST ? p[3*CW-1:2*CW] : p[CW-1:0];
  endfunction

  function automatic logic [CW-1:0] trail_c(input logic [PW-1:0] p);
    return CR_FIRST ? p[CW-1:0] : p[3*CW-1:2*CW];
  endfunction

  assign mate   = ph ? s2_pix : (in_de ? in_pix : s1_pix);
  assign ca     = ph ? trail_c(s1_pix) : lead_c(s1_pix);
  assign cb     = ph ? trail_c(mate)   : lead_c(mate);
  assign sum    = {1'b0, ca} + {1'b0, cb} + {{CW{1'b0}}, 1'b1};
  assign chroma = sum[CW:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_pix  <= '0;
      s2_pix  <= '0;
      s1_de   <= 1'b0;
      s1_hs   <= 1'b0;
      s1_vs   <= 1'b0;
      ph      <= 1'b0;
      out_de  <= 1'b0;
      out_hs  <= 1'b0;
      out_vs  <= 1'b0;
      out_pix <= '0;
      warm    <= '0;
    end else begin
      s1_pix  <= in_pix;
      s2_pix  <= s1_pix;
      s1_de   <= in_de;
      s1_hs   <= in_hs;
      s1_vs   <= in_vs;
      ph      <= (in_de && s1_de) ? ~ph : 1'b0;
      out_de  <= s1_de;
      out_hs  <= s1_hs;
      out_vs  <= s1_vs;
      if (bypass)     out_pix <= s1_pix;
      else if (s1_de) out_pix <= {{CW{1'b0}}, chroma, s1_pix[2*CW-1:CW]};
      else            out_pix <= '0;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  a_r2_de_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (out_de == $past(in_de, 2) && out_hs == $past(in_hs, 2) && out_vs == $past(in_vs, 2)));

  a_r8_bypass_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && $past(bypass)) |-> out_pix == $past(in_pix, 2));

  a_r3_luma_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && !$past(bypass) && out_de) |-> out_pix[CW-1:0] == $past(in_pix[2*CW-1:CW], 2));

  a_r3_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && !$past(bypass)) |-> out_pix[PW-1:2*CW] == '0);

  a_r10_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && !$past(bypass) && !out_de) |-> out_pix == '0);

  a_r6_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && s1_de && !$past(s1_de)) |-> !ph);

endmodule

// File: tb/test_chroma_sub422.sv
`timescale 1ns/1ps
module test_chroma_sub422;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass = 1'b0, in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [23:0] in_pix = '0;
  logic o0_de, o0_hs, o0_vs, o1_de, o1_hs, o1_vs;
  logic [23:0] o0_pix, o1_pix;

  always #2.5 clk = ~clk;

  chroma_sub422 #(.CR_FIRST(1'b0)) i_chroma_sub422 (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_de(in_de), .in_hs(in_hs),
    .in_vs(in_vs), .in_pix(in_pix), .out_de(o0_de), .out_hs(o0_hs),
    .out_vs(o0_vs), .out_pix(o0_pix));

  chroma_sub422 #(.CR_FIRST(1'b1)) i_chroma_sub422_cr (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_de(in_de), .in_hs(in_hs),
    .in_vs(in_vs), .in_pix(in_pix), .out_de(o1_de), .out_hs(o1_hs),
    .out_vs(o1_vs), .out_pix(o1_pix));

  localparam int DEPTH = 8192;
  logic [23:0] hp [0:DEPTH-1];
  bit hde [0:DEPTH-1];
  bit hhs [0:DEPTH-1];
  bit hvs [0:DEPTH-1];
  bit hby [0:DEPTH-1];
  int hpos [0:DEPTH-1];
  int n = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %h expected %h", tag, n, act, exp);
    end
  endtask

  function automatic logic [7:0] comp(input logic [23:0] p, input bit cr);
    return cr ? p[23:16] : p[7:0];
  endfunction

  task automatic check_one(input bit crf, input logic de, input logic hs, input logic vs,
                           input logic [23:0] pix);
    logic [23:0] p, m, e;
    int pos, s;
    string tag;
    p = hp[n-1];
    chk("R2 de", {23'd0, de}, {23'd0, hde[n-1]});
    chk("R2 hs", {23'd0, hs}, {23'd0, hhs[n-1]});
    chk("R2 vs", {23'd0, vs}, {23'd0, hvs[n-1]});
    if (hby[n]) begin
      chk("R8 R9 bypass", pix, p);
      return;
    end
    if (!hde[n-1]) begin
      chk("R10 blank", pix, 24'd0);
      return;
    end
    pos = hpos[n-1];
    if (pos % 2 == 0) begin
      m = hde[n] ? hp[n] : p;
      s = (int'(comp(p, crf)) + int'(comp(m, crf)) + 1) / 2;
      tag = !hde[n] ? "R7 lone" : (pos == 0 ? "R6 restart" : "R4 R5 lead");
    end else begin
      m = hp[n-2];
      s = (int'(comp(p, !crf)) + int'(comp(m, !crf)) + 1) / 2;
      tag = "R4 R5 trail";
    end
    e = {8'd0, s[7:0], p[15:8]};
    chk(tag, pix, e);
    chk("R3 luma", {16'd0, pix[7:0]}, {16'd0, p[15:8]});
  endtask

  task automatic step(input bit de, input bit hs, input bit vs, input logic [23:0] pix, input bit by);
    hp[n+1] = pix; hde[n+1] = de; hhs[n+1] = hs; hvs[n+1] = vs; hby[n+1] = by;
    hpos[n+1] = de ? (hde[n] ? hpos[n] + 1 : 0) : 0;
    in_de = de; in_hs = hs; in_vs = vs; in_pix = pix; bypass = by;
    @(posedge clk);
    n++;
    @(negedge clk);
    check_one(1'b0, o0_de, o0_hs, o0_vs, o0_pix);
    check_one(1'b1, o1_de, o1_hs, o1_vs, o1_pix);
  endtask

  task automatic line(input int len, input int gap, input bit by, input int flip_at);
    for (int i = 0; i < len; i++) step(1'b1, 1'b0, 1'b0, 24'($urandom), (i >= flip_at) ? ~by : by);
    for (int i = 0; i < gap; i++) step(1'b0, i < 2, 1'b0, 24'($urandom), by);
  endtask

  initial begin
    hp[0] = '0; hde[0] = 0; hhs[0] = 0; hvs[0] = 0; hby[0] = 0; hpos[0] = 0;
    in_pix = 24'hA5C3F1; in_de = 1'b1; in_hs = 1'b1; in_vs = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pix", o0_pix, 24'd0);
    chk("R1 reset syncs", {21'd0, o0_de, o0_hs, o0_vs}, 24'd0);
    chk("R1 reset pix cr", o1_pix, 24'd0);
    in_pix = '0; in_de = 1'b0; in_hs = 1'b0; in_vs = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, i < 2, 24'd0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 24'hFF01FF, 1'b0);
    step(1'b1, 1'b0, 1'b0, 24'h0002FE, 1'b0);
    step(1'b1, 1'b0, 1'b0, 24'h010380, 1'b0);
    step(1'b1, 1'b0, 1'b0, 24'h020481, 1'b0);
    step(1'b0, 1'b1, 1'b0, 24'd0, 1'b0);
    line(8, 3, 1'b0, 99);
    line(7, 1, 1'b0, 99);
    line(5, 1, 1'b0, 99);
    line(1, 1, 1'b0, 99);
    line(1, 2, 1'b0, 99);
    line(9, 4, 1'b1, 99);
    line(11, 3, 1'b0, 6);
    line(10, 3, 1'b1, 3);
    for (int k = 0; k < 40; k++) line(2 + int'($urandom_range(0, 30)), 1 + int'($urandom_range(0, 4)), 1'b0, 99);
    step(1'b1, 1'b1, 1'b1, 24'h123456, 1'b0);
    step(1'b1, 1'b0, 1'b1, 24'h654321, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 24'd0, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule